// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the register-level front end of an embedded flash array. Software writes a 32-bit command word that carries a key byte, a page number and an opcode. The controller checks the key and the opcode, whether a command is already in flight, and whether the target page is protected. A command that passes these checks waits for the first cycle on which the memory read port is idle, then runs for a fixed number of cycles. Reads that reach the port while the command runs are stalled.

Completion sets a ready flag and, when enabled, raises an interrupt. The two quick-read opcodes never raise it. Rejected commands set sticky error flags, and a status read clears them. The flash cells themselves are not modelled. A per-opcode latency counter stands in for them, next to a small page-buffer register file and sixteen region lock bits. The page buffer keeps its contents after a page write. Only an explicit clear command resets it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command word has the key 0xA5 in bits [31:24], the page number in bits [23:8] (only the low log2(PAGES) bits are used) and the opcode in bits [5:0]. The known opcodes are 0x01 write page, 0x02 erase page, 0x03 clear page buffer, 0x04 lock region, 0x05 unlock region, 0x06 erase all, 0x0C quick page read and 0x0F quick user-page read. A write with a wrong key or any other opcode is ignored: ready stays 1 and the programming-error flag is set.
- R2: An accepted command shows ready 0 from the edge that takes it. With the read port idle, ready returns to 1 after LAT+1 cycles. LAT is 16 for write page and erase page, 64 for erase all and 2 for every other opcode.
- R3: On completion of any opcode other than 0x0C or 0x0F, an interrupt becomes pending. The output irq is that pending state ANDed with the enable bit, which is control-write bit 0. Accepting a new command clears the pending state. A quick read leaves irq at 0.
- R4: A command written while another is pending or running is ignored and sets the programming-error flag. The command in flight finishes unchanged.
- R5: A write-page or erase-page command is ignored and sets the lock-error flag when its region is locked or its page number is below BOOT_PAGES. An erase-all command is treated the same way while any lock bit is set. Ready stays 1 in both cases.
- R6: Status layout: bit 0 ready, bit 1 programming error, bit 2 lock error, bit 3 interrupt enable, bits [31:16] region lock bits. A status read clears both error flags at the next edge. If a new error arrives in the same cycle as the read, that flag stays set.
- R7: An accepted command starts only on a cycle with rd_req low. While rd_req stays high the command remains pending, and rd_stall stays 0.
- R8: rd_stall is 1 whenever rd_req is 1 while a command is running, and it drops when the command completes.
- R9: The page buffer keeps its contents across a write-page command. A clear-page-buffer command sets every word to all ones, which is also the reset value.
- R10: Lock and unlock act on region page[PAGE_W-1:PAGE_W-4] at completion, and the result shows in status bits [31:16].
- R11: After reset the status word reads 0x00000001, irq is 0 and every page-buffer word reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: key, page, opcode |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word, bit 0 is the interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears the error flags |
| stat_rdata | output | 32 | Status word |
| rd_req | input | 1 | Read transfer present on the flash read port |
| rd_stall | output | 1 | Stall for the current read transfer |
| pb_wr | input | 1 | Page-buffer word write strobe |
| pb_waddr | input | 4 | Page-buffer write index |
| pb_wdata | input | 32 | Page-buffer write data |
| pb_raddr | input | 4 | Page-buffer read index |
| pb_rdata | output | 32 | Page-buffer read data |
| irq | output | 1 | Ready interrupt |

## Verification
Directed sequences cover several cases, each separating one pair of behaviours:
- Bad keys against bad opcodes.
- A command pending behind a read burst against one that runs at once, which shows whether the start waits for an idle cycle.
- Overlapping writes, which show whether the in-flight command is preserved.
- Locked and boot pages, which separate lock errors from programming errors.
- A status read in the same cycle as a new error, which tests the priority between clear and set.

A seeded random mix of valid and invalid keys, opcodes and pages then runs against a bench model of the lock bits, the error flags and the latency of each opcode. This exposes mismatches in decode, protection and timing across many combinations.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [7:0] CMD_KEY = 8'hA5;

  typedef enum logic [5:0] {
    OP_WRITE_PAGE = 6'h01,
    OP_ERASE_PAGE = 6'h02,
    OP_CLEAR_PB   = 6'h03,
    OP_LOCK       = 6'h04,
    OP_UNLOCK     = 6'h05,
    OP_ERASE_ALL  = 6'h06,
    OP_QREAD      = 6'h0C,
    OP_QREAD_USER = 6'h0F
  } fcc_op_e;

  function automatic logic op_known(input logic [5:0] op);
    case (op)
      OP_WRITE_PAGE, OP_ERASE_PAGE, OP_CLEAR_PB, OP_LOCK,
      OP_UNLOCK, OP_ERASE_ALL, OP_QREAD, OP_QREAD_USER: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_quick(input logic [5:0] op);
    return (op == OP_QREAD) || (op == OP_QREAD_USER);
  endfunction

  function automatic logic op_targets_page(input logic [5:0] op);
    return (op == OP_WRITE_PAGE) || (op == OP_ERASE_PAGE);
  endfunction

  function automatic int op_cycles(input logic [5:0] op, input int page_lat,
                                   input int all_lat, input int misc_lat);
    if (op_targets_page(op)) return page_lat;
    if (op == OP_ERASE_ALL) return all_lat;
    return misc_lat;
  endfunction
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode #(
  parameter int PAGE_W     = 8,
  parameter int BOOT_PAGES = 8
) (
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic              busy,
  input  logic [15:0]       locks,
  output logic              accept,
  output logic              prog_err,
  output logic              lock_err,
  output logic [5:0]        op,
  output logic [PAGE_W-1:0] page
);
  import fcc_pkg::*;

  localparam logic [PAGE_W:0] BOOT_LIM = (PAGE_W+1)'(BOOT_PAGES);

  logic       key_ok;
  logic       bad;
  logic       guarded;
  logic [3:0] region;
  logic       unused_fields;

  assign op     = cmd_wdata[5:0];
  assign page   = cmd_wdata[8 +: PAGE_W];
  assign region = page[PAGE_W-1 -: 4];
  assign key_ok = cmd_wdata[31:24] == CMD_KEY;
  assign unused_fields = ^{cmd_wdata[7:6], cmd_wdata[23:8+PAGE_W]};

  always_comb begin
    bad     = !key_ok || !op_known(op) || busy;
    guarded = (op_targets_page(op) && (locks[region] || ({1'b0, page} < BOOT_LIM)))
            || ((op == OP_ERASE_ALL) && (|locks));
    prog_err = cmd_wr && bad;
    lock_err = cmd_wr && !bad && guarded;
    accept   = cmd_wr && !bad && !guarded;
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq #(
  parameter int PAGE_W   = 8,
  parameter int PAGE_LAT = 16,
  parameter int ALL_LAT  = 64,
  parameter int MISC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [5:0]        op_in,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              rd_req,
  output logic              pending,
  output logic              running,
  output logic              start,
  output logic              done,
  output logic [5:0]        op_q,
  output logic [PAGE_W-1:0] page_q
);
  localparam int HI_A    = (ALL_LAT > PAGE_LAT) ? ALL_LAT : PAGE_LAT;
  localparam int MAX_LAT = (HI_A > MISC_LAT) ? HI_A : MISC_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt;
  int               lat;

  assign lat   = fcc_pkg::op_cycles(op_q, PAGE_LAT, ALL_LAT, MISC_LAT);
  assign start = pending && !rd_req;
  assign done  = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      op_q    <= '0;
      page_q  <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      op_q    <= op_in;
      page_q  <= page_in;
    end else if (start) begin
      pending <= 1'b0;
      running <= 1'b1;
      cnt     <= CNT_W'(lat - 1);
    end else if (done) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fcc_locks.sv
module fcc_locks (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  logic [5:0]  op,
  input  logic [3:0]  region,
  output logic [15:0] locks
);
  import fcc_pkg::*;

  for (genvar g = 0; g < 16; g++) begin : g_region
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) locks[g] <= 1'b0;
      else if (done && (region == 4'(g))) begin
        if (op == OP_LOCK) locks[g] <= 1'b1;
        else if (op == OP_UNLOCK) locks[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcc_pagebuf.sv
module fcc_pagebuf #(
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          clr,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= '1;
      else if (clr) mem[w] <= '1;
      else if (wr && (waddr == AW'(w))) mem[w] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int PAGES      = 256,
  parameter int BOOT_PAGES = 8,
  parameter int PB_WORDS   = 16,
  parameter int PAGE_LAT   = 16,
  parameter int ALL_LAT    = 64,
  parameter int MISC_LAT   = 2,
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int PB_AW     = $clog2(PB_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  input  logic             stat_rd,
  output logic [31:0]      stat_rdata,
  input  logic             rd_req,
  output logic             rd_stall,
  input  logic             pb_wr,
  input  logic [PB_AW-1:0] pb_waddr,
  input  logic [31:0]      pb_wdata,
  input  logic [PB_AW-1:0] pb_raddr,
  output logic [31:0]      pb_rdata,
  output logic             irq
);
  import fcc_pkg::*;

  logic              cmd_accept, cmd_prog_err, cmd_lock_err;
  logic              exec_start, exec_done, exec_quick;
  logic              pending, running;
  logic [5:0]        dec_op, op_q;
  logic [PAGE_W-1:0] dec_page, page_q;
  logic [15:0]       locks;
  logic              prog_err_q, lock_err_q, irq_en_q, irq_pend_q;
  logic              unused_ctl;

  assign unused_ctl = ^ctl_wdata[31:1];
  assign exec_quick = op_is_quick(op_q);

  fcc_decode #(.PAGE_W(PAGE_W), .BOOT_PAGES(BOOT_PAGES)) u_dec (
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .busy(pending || running),
    .locks(locks), .accept(cmd_accept), .prog_err(cmd_prog_err),
    .lock_err(cmd_lock_err), .op(dec_op), .page(dec_page)
  );

  fcc_seq #(.PAGE_W(PAGE_W), .PAGE_LAT(PAGE_LAT), .ALL_LAT(ALL_LAT),
            .MISC_LAT(MISC_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(cmd_accept), .op_in(dec_op),
    .page_in(dec_page), .rd_req(rd_req), .pending(pending),
    .running(running), .start(exec_start), .done(exec_done),
    .op_q(op_q), .page_q(page_q)
  );

  fcc_locks u_locks (
    .clk(clk), .rst_n(rst_n), .done(exec_done), .op(op_q),
    .region(page_q[PAGE_W-1 -: 4]), .locks(locks)
  );

  fcc_pagebuf #(.WORDS(PB_WORDS)) u_pb (
    .clk(clk), .rst_n(rst_n), .wr(pb_wr), .waddr(pb_waddr),
    .wdata(pb_wdata), .clr(exec_done && (op_q == OP_CLEAR_PB)),
    .raddr(pb_raddr), .rdata(pb_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_err_q <= 1'b0;
      lock_err_q <= 1'b0;
      irq_en_q   <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      if (cmd_prog_err)  prog_err_q <= 1'b1;
      else if (stat_rd)  prog_err_q <= 1'b0;
      if (cmd_lock_err)  lock_err_q <= 1'b1;
      else if (stat_rd)  lock_err_q <= 1'b0;
      if (ctl_wr)        irq_en_q   <= ctl_wdata[0];
      if (cmd_accept)    irq_pend_q <= 1'b0;
      else if (exec_done && !exec_quick) irq_pend_q <= 1'b1;
    end
  end

  assign stat_rdata = {locks, 12'd0, irq_en_q, lock_err_q, prog_err_q,
                       !(pending || running)};
  assign rd_stall   = rd_req && running;
  assign irq        = irq_en_q && irq_pend_q;
endmodule

// File: rtl/fcc_checks.sv
module fcc_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_accept,
  input logic        cmd_prog_err,
  input logic        cmd_lock_err,
  input logic        exec_start,
  input logic        exec_done,
  input logic        exec_quick,
  input logic        rd_req,
  input logic        rd_stall,
  input logic        stat_rd,
  input logic [31:0] stat_rdata,
  input logic        irq
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !stat_rdata[0]); // R2
  AST_DONE_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_done |=> stat_rdata[0]); // R2
  AST_BAD_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_prog_err |=> stat_rdata[1]); // R1
  AST_LOCK_FLAG_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lock_err |=> (stat_rdata[2] && stat_rdata[0])); // R5
  AST_QUICK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && exec_quick) |=> !irq); // R3
  AST_START_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> !rd_req); // R7
  AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_req && !stat_rdata[0])); // R8
  AST_READ_CLEARS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_prog_err) |=> !stat_rdata[1]); // R6
  AST_READ_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_lock_err) |=> !stat_rdata[2]); // R6
endmodule

bind flash_cmd_ctrl fcc_checks u_fcc_checks (
  .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept),
  .cmd_prog_err(cmd_prog_err), .cmd_lock_err(cmd_lock_err),
  .exec_start(exec_start), .exec_done(exec_done), .exec_quick(exec_quick),
  .rd_req(rd_req), .rd_stall(rd_stall), .stat_rd(stat_rd),
  .stat_rdata(stat_rdata), .irq(irq)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, ctl_wr = 1'b0, stat_rd = 1'b0, rd_req = 1'b0, pb_wr = 1'b0;
  logic [31:0] cmd_wdata = '0, ctl_wdata = '0, pb_wdata = '0;
  logic [3:0]  pb_waddr = '0, pb_raddr = '0;
  logic [31:0] stat_rdata, pb_rdata;
  logic        rd_stall, irq;
  int          checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .rd_req(rd_req), .rd_stall(rd_stall),
    .pb_wr(pb_wr), .pb_waddr(pb_waddr), .pb_wdata(pb_wdata),
    .pb_raddr(pb_raddr), .pb_rdata(pb_rdata), .irq(irq)
  );

  function automatic int b_lat(input logic [5:0] op);
    if (op == 6'h01 || op == 6'h02) return 16;
    if (op == 6'h06) return 64;
    return 2;
  endfunction

  function automatic bit b_known(input logic [5:0] op);
    return op inside {6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h0C, 6'h0F};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] key, input logic [5:0] op, input logic [15:0] page);
    cmd_wr = 1'b1;
    cmd_wdata = {key, page, 2'b00, op};
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!stat_rdata[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_status(output logic [31:0] v);
    v = stat_rdata;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] st;
    logic [15:0] mlocks;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 status", stat_rdata, 32'h1);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    pb_raddr = 4'd9;
    #0.1 chk("R11 pagebuf", pb_rdata, 32'hFFFF_FFFF);

    // R1 wrong key, then unknown opcode
    issue(8'h5A, 6'h01, 16'd100);
    chk("R1 badkey ready", {31'd0, stat_rdata[0]}, 32'd1);
    chk("R1 badkey prog_err", {31'd0, stat_rdata[1]}, 32'd1);
    read_status(st);
    chk("R6 flag seen on read", {31'd0, st[1]}, 32'd1);
    chk("R6 cleared after read", stat_rdata[2:0], 3'b001);
    issue(8'hA5, 6'h3F, 16'd100);
    chk("R1 badop prog_err", stat_rdata[2:0], 3'b011);
    read_status(st);

    // R2 latency per opcode class
    issue(8'hA5, 6'h01, 16'd100);
    chk("R2 ready drops", {31'd0, stat_rdata[0]}, 32'd0);
    wait_ready(n);
    chk("R2 write page latency", n, 17);
    issue(8'hA5, 6'h06, 16'd0);
    wait_ready(n);
    chk("R2 erase all latency", n, 65);
    issue(8'hA5, 6'h0C, 16'd20);
    wait_ready(n);
    chk("R2 quick read latency", n, 3);

    // R10 lock region 3, R5 lock and boot protection
    issue(8'hA5, 6'h04, 16'h0035);
    wait_ready(n);
    chk("R10 lock bit set", {16'd0, stat_rdata[31:16]}, 32'h0008);
    issue(8'hA5, 6'h01, 16'h0030);
    chk("R5 locked page rejected", stat_rdata[2:0], 3'b101);
    read_status(st);
    issue(8'hA5, 6'h06, 16'h0);
    chk("R5 erase all while locked", stat_rdata[2:0], 3'b101);
    read_status(st);
    issue(8'hA5, 6'h05, 16'h003F);
    wait_ready(n);
    chk("R10 unlock clears", {16'd0, stat_rdata[31:16]}, 32'h0);
    issue(8'hA5, 6'h02, 16'h0030);
    chk("R5 unlocked page accepted", {31'd0, stat_rdata[0]}, 32'd0);
    wait_ready(n);
    issue(8'hA5, 6'h01, 16'd5);
    chk("R5 boot page rejected", stat_rdata[2:0], 3'b101);
    read_status(st);

    // R3 interrupt
    ctl_wr = 1'b1; ctl_wdata = 32'd1;
    @(negedge clk);
    ctl_wr = 1'b0;
    issue(8'hA5, 6'h01, 16'd100);
    wait_ready(n);
    chk("R3 irq after write", {31'd0, irq}, 32'd1);
    issue(8'hA5, 6'h0F, 16'd100);
    chk("R3 irq cleared on accept", {31'd0, irq}, 32'd0);
    wait_ready(n);
    chk("R3 quick read no irq", {31'd0, irq}, 32'd0);

    // R4 overlap
    issue(8'hA5, 6'h01, 16'd200);
    issue(8'hA5, 6'h04, 16'd200);
    chk("R4 overlap prog_err", {31'd0, stat_rdata[1]}, 32'd1);
    wait_ready(n);
    read_status(st);
    chk("R4 overlap lock ignored", {16'd0, st[31:16]}, 32'd0);

    // R6 new error beats a status read
    issue(8'h00, 6'h01, 16'd100);
    stat_rd = 1'b1; cmd_wr = 1'b1; cmd_wdata = 32'h0000_0001;
    @(negedge clk);
    stat_rd = 1'b0; cmd_wr = 1'b0;
    chk("R6 new error wins", {31'd0, stat_rdata[1]}, 32'd1);
    read_status(st);

    // R7 pending behind reads, R8 stall while running
    rd_req = 1'b1;
    issue(8'hA5, 6'h02, 16'd50);
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk("R7 still pending", {30'd0, stat_rdata[0], rd_stall}, 32'd0);
    rd_req = 1'b0;
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    chk("R8 stall while running", {31'd0, rd_stall}, 32'd1);
    wait_ready(n);
    chk("R8 stall released", {31'd0, rd_stall}, 32'd0);
    chk("R7 run length after start", n, 15);
    rd_req = 1'b0;

    // R9 page buffer
    for (int w = 0; w < 16; w++) begin
      pb_wr = 1'b1; pb_waddr = 4'(w); pb_wdata = 32'h1000 + 32'(w) * 7;
      @(negedge clk);
    end
    pb_wr = 1'b0;
    issue(8'hA5, 6'h01, 16'd120);
    wait_ready(n);
    pb_raddr = 4'd7;
    #0.1 chk("R9 kept after write", pb_rdata, 32'h1000 + 49);
    issue(8'hA5, 6'h03, 16'd0);
    wait_ready(n);
    for (int w = 0; w < 16; w += 5) begin
      pb_raddr = 4'(w);
      #0.1 chk("R9 cleared", pb_rdata, 32'hFFFF_FFFF);
    end

    // Random mix against a model, R1 R2 R5 R10
    void'($urandom(32'd7));
    mlocks = '0;
    for (int it = 0; it < 200; it++) begin
      logic [7:0]  key;
      logic [5:0]  op;
      logic [15:0] pg;
      bit pe, le;
      logic [5:0] pool [10] = '{6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h0C, 6'h0F, 6'h3F, 6'h07};
      key = ($urandom % 10 == 0) ? 8'h5B : 8'hA5;
      op  = pool[$urandom % 10];
      pg  = 16'($urandom % 256);
      pe  = (key != 8'hA5) || !b_known(op);
      le  = !pe && ((((op == 6'h01) || (op == 6'h02)) && (mlocks[pg[7:4]] || pg < 8))
                    || ((op == 6'h06) && (mlocks != 0)));
      issue(key, op, pg);
      if (!pe && !le) begin
        wait_ready(n);
        chk("R2 random latency", n, b_lat(op) + 1);
        if (op == 6'h04) mlocks[pg[7:4]] = 1'b1;
        if (op == 6'h05) mlocks[pg[7:4]] = 1'b0;
      end
      read_status(st);
      chk("R1 R5 random flags", {st[31:16], 13'd0, st[2:0]},
          {mlocks, 13'd0, le, pe, 1'b1});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule